// File: doc/BRIEF.md
# Command-Word I2C Bus Master

This block is an I2C bus master driven by software one command word at a time. Each 11-bit word carries a 3-bit operation code and an 8-bit data or address byte. The word lands in a single-entry buffer. When the bus engine is free, it takes the word and runs the matching byte-level phase: a start condition followed by an address byte, a repeated start, a stop, a byte write, or a byte read answered with ACK or NACK.

The engine does not fix the bus sequence. Software builds every transaction from these phases and chooses, read byte by read byte, whether the master acknowledges. Bit timing comes from an integer prescaler that generates time quanta. A mode input selects a standard bit period of 10 quanta or a fast bit period of 25 quanta. Both pins are open-drain: each output means "pull low" when 1 and "release" when 0.

Top module: `i2c_cmd_engine`

## Requirements
- R1: A command word is `cmdWord[10:8]` = code and `cmdWord[7:0]` = byte. A write strobe is accepted only when `chanOn` is 1 and `bufValid` is 0. An accepted write sets `bufValid` on the next cycle. A write while `bufValid` is 1 is dropped and never reaches the bus.
- R2: When the engine takes the word from the buffer, `bufValid` falls and `tbufInd` pulses high for exactly one cycle.
- R3: One quantum lasts `prescale`+1 clock cycles. With `fastMode`=0 a bit lasts 10 quanta, and SCL is pulled low for the first 5 and released for the last 5. With `fastMode`=1 a bit lasts 25 quanta, and SCL is low for 15 and released for 10.
- R4: Code 4 from a free bus makes SDA fall while SCL is released (a start). The engine then sends the word's byte as an address byte, MSB first, with bit 0 as the direction bit.
- R5: Code 0 sends the byte MSB first, and SDA changes only while SCL is low. In the ninth bit the master releases SDA and samples it in the middle of the high phase. `nackRcvd` becomes 1 if SDA was high and 0 otherwise.
- R6: Codes 2 and 3 clock in 8 bits, MSB first, sampled in the middle of each high phase. In the ninth bit the master pulls SDA low for code 2 and releases it for code 3. At the end of that bit, `rxData` takes the byte and `rxValid` pulses for one cycle.
- R7: Code 6 while the master holds the bus pulls SDA low while SCL is low, then releases SDA while SCL is high (a stop), after which both pins stay released. Code 6 on a free bus causes no bus activity.
- R8: Code 5, or code 4 while the master holds the bus, first releases SDA during the low half of an extra bit, then generates a start and sends the address byte.
- R9: Codes 1 and 7 are consumed from the buffer (so `tbufInd` pulses) and set `cmdError`, with no bus activity. `cmdError` and `nackRcvd` clear when the next word is taken.
- R10: An idle request while `bufValid` is 1 gives a one-cycle `idleRefused` pulse and leaves `chanOn` at 1. With the buffer empty, the request clears `chanOn`, and writes are then ignored until an enable request sets `chanOn` again.
- R11: After reset both pins are released, `bufValid`, `cmdError`, `nackRcvd`, `rxValid` and `engineBusy` are 0, and `chanOn` is 1.
- R12: `engineBusy` is 1 exactly while a bus phase is running, and a new word is taken only when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| fastMode | input | 1 | 0: 10 quanta per bit, 1: 25 quanta per bit |
| prescale | input | 8 | Quantum length minus one, in clock cycles |
| cmdWord | input | 11 | Code in bits 10:8, byte in bits 7:0 |
| cmdWrite | input | 1 | Write strobe for `cmdWord` |
| chanEnReq | input | 1 | Request to enable the channel |
| chanIdleReq | input | 1 | Request to idle the channel |
| sdaIn | input | 1 | Sensed SDA line level |
| bufValid | output | 1 | Command buffer holds a word |
| tbufInd | output | 1 | Pulse: word taken from buffer |
| chanOn | output | 1 | Channel enabled |
| idleRefused | output | 1 | Pulse: idle request refused |
| engineBusy | output | 1 | Bus phase in progress |
| rxData | output | 8 | Last received byte |
| rxValid | output | 1 | Pulse: `rxData` updated |
| nackRcvd | output | 1 | Slave did not acknowledge the last byte |
| cmdError | output | 1 | Last word had an illegal code |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |

## Verification
A wrong state in the phase sequencer shows up on the pins within one bit period. It appears either as an extra or missing start or stop, or as a byte that decodes wrongly at the SCL rising edges. A miscounted quantum or prescaler shows up as a wrong SCL low or high length on the very first bit. A slipped bit counter appears after nine bits as a wrong received byte, a misplaced acknowledge or a stale `nackRcvd`. A buffer or flag fault shows up in the cycle after the take, through `bufValid`, `tbufInd` or `cmdError`.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  localparam int CODE_W = 3;
  localparam int DATA_W = 8;
  localparam int CMD_W  = CODE_W + DATA_W;

  typedef enum logic [CODE_W-1:0] {
    CMD_WR   = 3'd0,
    CMD_SLV  = 3'd1,
    CMD_RDA  = 3'd2,
    CMD_RDN  = 3'd3,
    CMD_STA  = 3'd4,
    CMD_RSTA = 3'd5,
    CMD_STO  = 3'd6,
    CMD_BAD  = 3'd7
  } cmd_code_e;

  typedef enum logic [2:0] {
    ST_FREE, ST_HELD, ST_REL, ST_START, ST_BYTE, ST_STOP
  } eng_state_e;

  typedef enum logic [1:0] {
    SCL_FREE, SCL_LOW, SCL_PULSE
  } scl_mode_e;

  typedef enum logic [1:0] {
    SDA_KEEP, SDA_LOW, SDA_REL, SDA_TX
  } sda_op_e;

  typedef struct packed {
    logic      runSlot;
    scl_mode_e sclMode;
    sda_op_e   sdaOp;
    logic      txLoad;
    logic      rxShift;
    logic      rxCommit;
  } strobe_t;

  typedef struct packed {
    logic lowMid;
    logic highMid;
    logic slotLast;
  } timing_t;

endpackage

// File: rtl/i2c_cmd_dp.sv
module i2c_cmd_dp
  import i2c_cmd_pkg::*;
#(
  parameter int PRE_W    = 8,
  parameter int STD_Q    = 10,
  parameter int STD_LOW  = 5,
  parameter int FAST_Q   = 25,
  parameter int FAST_LOW = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fastMode,
  input  logic [PRE_W-1:0]  prescale,
  input  logic              sdaIn,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] txByte,
  output timing_t           tim,
  output logic              sclOe,
  output logic              sdaOe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid
);

  localparam int QW = $clog2(FAST_Q + 1);

  logic [PRE_W-1:0]  preCnt;
  logic [QW-1:0]     q, qLast, qLow, qLowMid, qHighMid;
  logic              qTick;
  logic [DATA_W-1:0] txSh, rxSh;

  // Quantum positions for the selected bit period
  always_comb begin
    if (fastMode) begin
      qLast    = QW'(FAST_Q - 1);
      qLow     = QW'(FAST_LOW);
      qLowMid  = QW'(FAST_LOW / 2);
      qHighMid = QW'(FAST_LOW + (FAST_Q - FAST_LOW) / 2);
    end else begin
      qLast    = QW'(STD_Q - 1);
      qLow     = QW'(STD_LOW);
      qLowMid  = QW'(STD_LOW / 2);
      qHighMid = QW'(STD_LOW + (STD_Q - STD_LOW) / 2);
    end
  end

  assign qTick        = stb.runSlot && (preCnt == prescale);
  assign tim.lowMid   = qTick && (q == qLowMid);
  assign tim.highMid  = qTick && (q == qHighMid);
  assign tim.slotLast = qTick && (q == qLast);

  assign sclOe = (stb.sclMode == SCL_LOW) ||
                 ((stb.sclMode == SCL_PULSE) && (q < qLow));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      q      <= '0;
    end else if (!stb.runSlot) begin
      preCnt <= '0;
      q      <= '0;
    end else if (qTick) begin
      preCnt <= '0;
      q      <= (q == qLast) ? '0 : q + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdaOe   <= 1'b0;
      txSh    <= '0;
      rxSh    <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= stb.rxCommit;
      if (stb.txLoad) begin
        txSh <= txByte;
      end else if (stb.sdaOp == SDA_TX) begin
        txSh <= {txSh[DATA_W-2:0], 1'b0};
      end
      case (stb.sdaOp)
        SDA_LOW: sdaOe <= 1'b1;
        SDA_REL: sdaOe <= 1'b0;
        SDA_TX:  sdaOe <= ~txSh[DATA_W-1];
        default: sdaOe <= sdaOe;
      endcase
      if (stb.rxShift) rxSh <= {rxSh[DATA_W-2:0], sdaIn};
      if (stb.rxCommit) rxData <= rxSh;
    end
  end

endmodule

// File: rtl/i2c_cmd_ctrl.sv
module i2c_cmd_ctrl
  import i2c_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic              cmdWrite,
  input  logic              chanEnReq,
  input  logic              chanIdleReq,
  input  logic              sdaIn,
  input  timing_t           tim,
  output strobe_t           stb,
  output logic [DATA_W-1:0] txByte,
  output logic              bufValid,
  output logic              tbufInd,
  output logic              chanOn,
  output logic              idleRefused,
  output logic              engineBusy,
  output logic              nackRcvd,
  output logic              cmdError
);

  localparam int BIT_W = $clog2(DATA_W + 2);
  localparam logic [BIT_W-1:0] ACK_BIT = BIT_W'(DATA_W);

  eng_state_e       state;
  logic [CMD_W-1:0] bufWord;
  logic [BIT_W-1:0] bitCnt;
  logic             isRead, ackLow, take, ackSlot;
  cmd_code_e        code;

  assign code       = cmd_code_e'(bufWord[CMD_W-1:DATA_W]);
  assign txByte     = bufWord[DATA_W-1:0];
  assign take       = bufValid && ((state == ST_FREE) || (state == ST_HELD));
  assign engineBusy = !((state == ST_FREE) || (state == ST_HELD));
  assign ackSlot    = (bitCnt == ACK_BIT);

  // Strobes towards the datapath
  always_comb begin
    stb = '{runSlot: 1'b0, sclMode: SCL_FREE, sdaOp: SDA_KEEP,
            txLoad: 1'b0, rxShift: 1'b0, rxCommit: 1'b0};
    stb.txLoad = take && ((code == CMD_WR) || (code == CMD_STA) || (code == CMD_RSTA));
    case (state)
      ST_HELD: stb.sclMode = SCL_LOW;
      ST_REL: begin
        stb.runSlot = 1'b1;
        stb.sclMode = SCL_PULSE;
        if (tim.lowMid) stb.sdaOp = SDA_REL;
      end
      ST_START: begin
        stb.runSlot = 1'b1;
        if (tim.highMid) stb.sdaOp = SDA_LOW;
      end
      ST_BYTE: begin
        stb.runSlot = 1'b1;
        stb.sclMode = SCL_PULSE;
        if (tim.lowMid) begin
          if (!ackSlot)     stb.sdaOp = isRead ? SDA_REL : SDA_TX;
          else              stb.sdaOp = (isRead && ackLow) ? SDA_LOW : SDA_REL;
        end
        if (tim.highMid && !ackSlot && isRead) stb.rxShift = 1'b1;
        if (tim.slotLast && ackSlot && isRead) stb.rxCommit = 1'b1;
      end
      ST_STOP: begin
        stb.runSlot = 1'b1;
        stb.sclMode = SCL_PULSE;
        if (tim.lowMid)  stb.sdaOp = SDA_LOW;
        if (tim.highMid) stb.sdaOp = SDA_REL;
      end
      default: ;
    endcase
  end

  // Buffer and channel state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufValid    <= 1'b0;
      bufWord     <= '0;
      tbufInd     <= 1'b0;
      chanOn      <= 1'b1;
      idleRefused <= 1'b0;
    end else begin
      tbufInd     <= take;
      idleRefused <= chanIdleReq && bufValid;
      if (chanIdleReq && !bufValid) chanOn <= 1'b0;
      else if (chanEnReq)           chanOn <= 1'b1;
      if (take) begin
        bufValid <= 1'b0;
      end else if (cmdWrite && chanOn && !bufValid) begin
        bufValid <= 1'b1;
        bufWord  <= cmdWord;
      end
    end
  end

  // Phase sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_FREE;
      bitCnt   <= '0;
      isRead   <= 1'b0;
      ackLow   <= 1'b0;
      nackRcvd <= 1'b0;
      cmdError <= 1'b0;
    end else begin
      case (state)
        ST_FREE, ST_HELD: begin
          if (take) begin
            nackRcvd <= 1'b0;
            cmdError <= 1'b0;
            bitCnt   <= '0;
            case (code)
              CMD_WR: begin
                isRead <= 1'b0;
                state  <= ST_BYTE;
              end
              CMD_RDA, CMD_RDN: begin
                isRead <= 1'b1;
                ackLow <= (code == CMD_RDA);
                state  <= ST_BYTE;
              end
              CMD_STA, CMD_RSTA: begin
                isRead <= 1'b0;
                state  <= (state == ST_HELD) ? ST_REL : ST_START;
              end
              CMD_STO: state <= (state == ST_HELD) ? ST_STOP : ST_FREE;
              default: cmdError <= 1'b1;
            endcase
          end
        end
        ST_REL:   if (tim.slotLast) state <= ST_START;
        ST_START: if (tim.slotLast) begin
          bitCnt <= '0;
          state  <= ST_BYTE;
        end
        ST_BYTE: begin
          if (tim.highMid && ackSlot && !isRead) nackRcvd <= sdaIn;
          if (tim.slotLast) begin
            if (ackSlot) state <= ST_HELD;
            else         bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_STOP:  if (tim.slotLast) state <= ST_FREE;
        default:  state <= ST_FREE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_cmd_pkg::*;
#(
  parameter int PRE_W    = 8,
  parameter int STD_Q    = 10,
  parameter int STD_LOW  = 5,
  parameter int FAST_Q   = 25,
  parameter int FAST_LOW = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fastMode,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic              cmdWrite,
  input  logic              chanEnReq,
  input  logic              chanIdleReq,
  input  logic              sdaIn,
  output logic              bufValid,
  output logic              tbufInd,
  output logic              chanOn,
  output logic              idleRefused,
  output logic              engineBusy,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              nackRcvd,
  output logic              cmdError,
  output logic              sclOe,
  output logic              sdaOe
);

  strobe_t           stb;
  timing_t           tim;
  logic [DATA_W-1:0] txByte;

  i2c_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWord(cmdWord), .cmdWrite(cmdWrite),
    .chanEnReq(chanEnReq), .chanIdleReq(chanIdleReq), .sdaIn(sdaIn),
    .tim(tim), .stb(stb), .txByte(txByte), .bufValid(bufValid),
    .tbufInd(tbufInd), .chanOn(chanOn), .idleRefused(idleRefused),
    .engineBusy(engineBusy), .nackRcvd(nackRcvd), .cmdError(cmdError)
  );

  i2c_cmd_dp #(
    .PRE_W(PRE_W), .STD_Q(STD_Q), .STD_LOW(STD_LOW),
    .FAST_Q(FAST_Q), .FAST_LOW(FAST_LOW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .fastMode(fastMode), .prescale(prescale),
    .sdaIn(sdaIn), .stb(stb), .txByte(txByte), .tim(tim),
    .sclOe(sclOe), .sdaOe(sdaOe), .rxData(rxData), .rxValid(rxValid)
  );

endmodule

// File: rtl/i2c_cmd_chk.sv
module i2c_cmd_chk (
  input logic clk,
  input logic rstN,
  input logic cmdWrite,
  input logic chanIdleReq,
  input logic bufValid,
  input logic tbufInd,
  input logic chanOn,
  input logic idleRefused,
  input logic engineBusy,
  input logic rxValid,
  input logic cmdError
);

  assert_fill_gate_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufValid) |-> $past(cmdWrite) && $past(chanOn));

  assert_take_empties_R2: assert property (@(posedge clk) disable iff (!rstN)
    tbufInd |-> !bufValid);

  assert_tbuf_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    tbufInd |=> !tbufInd);

  assert_rx_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_err_on_take_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdError) |-> tbufInd);

  assert_refuse_full_R10: assert property (@(posedge clk) disable iff (!rstN)
    idleRefused |-> $past(bufValid) && $past(chanIdleReq));

  assert_idle_empty_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(chanOn) |-> !$past(bufValid));

  assert_take_when_free_R12: assert property (@(posedge clk) disable iff (!rstN)
    tbufInd |-> !$past(engineBusy));

endmodule

bind i2c_cmd_engine i2c_cmd_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .chanIdleReq(chanIdleReq),
  .bufValid(bufValid), .tbufInd(tbufInd), .chanOn(chanOn),
  .idleRefused(idleRefused), .engineBusy(engineBusy), .rxValid(rxValid),
  .cmdError(cmdError)
);

// File: tb/sim_i2c_cmd_engine.sv
`timescale 1ns/1ps
module sim_i2c_cmd_engine;

  localparam int ROLE_NONE = 0, ROLE_ACK = 1, ROLE_NACK = 2, ROLE_SEND = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fastMode = 1'b0;
  logic [7:0]  prescale = 8'd1;
  logic [10:0] cmdWord = '0;
  logic        cmdWrite = 1'b0, chanEnReq = 1'b0, chanIdleReq = 1'b0;
  logic        sdaIn;
  logic        bufValid, tbufInd, chanOn, idleRefused, engineBusy;
  logic [7:0]  rxData;
  logic        rxValid, nackRcvd, cmdError, sclOe, sdaOe;

  logic        slaveLow = 1'b0;
  int          role = ROLE_NONE;
  logic [7:0]  sendByte = '0;

  assign sdaIn = ~(sdaOe | slaveLow);

  always #10 clk = ~clk;

  i2c_cmd_engine u0 (
    .clk(clk), .rstN(rstN), .fastMode(fastMode), .prescale(prescale),
    .cmdWord(cmdWord), .cmdWrite(cmdWrite), .chanEnReq(chanEnReq),
    .chanIdleReq(chanIdleReq), .sdaIn(sdaIn), .bufValid(bufValid),
    .tbufInd(tbufInd), .chanOn(chanOn), .idleRefused(idleRefused),
    .engineBusy(engineBusy), .rxData(rxData), .rxValid(rxValid),
    .nackRcvd(nackRcvd), .cmdError(cmdError), .sclOe(sclOe), .sdaOe(sdaOe)
  );

  int nChecks = 0, nFails = 0, cyc = 0;
  int startCnt = 0, stopCnt = 0, riseCnt = 0, byteCnt = 0, tbCnt = 0, rxCnt = 0;
  int bitK = 0, runLen = 0, lastHigh = 0, lastLow = 0;
  logic [8:0] sh9 = '0;
  logic [7:0] lastByte = '0;
  logic       lastAck = 1'b0, prevScl = 1'b1, prevSda = 1'b1;

  function automatic int expLow(input logic f, input int p);
    return (f ? 15 : 5) * (p + 1);
  endfunction
  function automatic int expHigh(input logic f, input int p);
    return (f ? 10 : 5) * (p + 1);
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bus monitor and slave model
  always @(negedge clk) begin
    logic sclL, sdaL;
    sclL = !sclOe;
    sdaL = sdaIn;
    if (!rstN) begin
      prevScl = 1'b1; prevSda = 1'b1; bitK = 0; runLen = 0; slaveLow = 1'b0;
    end else begin
      if (sclL && !prevScl) begin
        sh9 = {sh9[7:0], sdaL};
        bitK++; riseCnt++;
        if (bitK == 9) begin
          lastByte = sh9[8:1]; lastAck = sh9[0]; byteCnt++; bitK = 0;
        end
      end else if (sclL && prevScl && prevSda && !sdaL) begin
        startCnt++; bitK = 0;
      end else if (sclL && prevScl && !prevSda && sdaL) begin
        stopCnt++; bitK = 0;
      end
      if (sclL == prevScl) runLen++;
      else begin
        if (prevScl) lastHigh = runLen; else lastLow = runLen;
        runLen = 1;
      end
      if (tbufInd) tbCnt++;
      if (rxValid) rxCnt++;
      prevScl = sclL; prevSda = sdaL;
      if (!sclL) begin
        case (role)
          ROLE_ACK:  slaveLow = (bitK == 8);
          ROLE_SEND: slaveLow = (bitK < 8) && !sendByte[7 - bitK];
          default:   slaveLow = 1'b0;
        endcase
      end
    end
  end

  task automatic putCmd(input logic [2:0] c, input logic [7:0] d);
    while (bufValid) @(negedge clk);
    cmdWord  = {c, d};
    cmdWrite = 1'b1;
    @(negedge clk);
    cmdWrite = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (bufValid || engineBusy);
    #2;
  endtask

  task automatic doWrite(input logic [7:0] d, input logic ack);
    int b;
    role = ack ? ROLE_ACK : ROLE_NACK;
    b = byteCnt;
    putCmd(3'd0, d); waitIdle();
    check("R5", "written byte", lastByte, d);
    check("R5", "byte count", byteCnt, b + 1);
    check("R5", "nackRcvd", nackRcvd, !ack);
  endtask

  task automatic doRead(input logic [7:0] d, input logic ackIt);
    int r;
    role = ROLE_SEND; sendByte = d;
    r = rxCnt;
    putCmd(ackIt ? 3'd2 : 3'd3, 8'h00); waitIdle();
    check("R6", "rxData", rxData, d);
    check("R6", "rxValid pulses", rxCnt, r + 1);
    check("R6", "master ack bit", lastAck, !ackIt);
    role = ROLE_NONE;
  endtask

  task automatic doStart(input logic [2:0] c, input logic [7:0] a, input string req);
    int s;
    role = ROLE_ACK;
    s = startCnt;
    putCmd(c, a); waitIdle();
    check(req, "start count", startCnt, s + 1);
    check(req, "address byte", lastByte, a);
    check(req, "cmdError cleared", cmdError, 0);
  endtask

  task automatic doStop();
    int s;
    role = ROLE_NONE;
    @(negedge clk);
    s = stopCnt;
    putCmd(3'd6, 8'h00); waitIdle();
    check("R7", "stop count", stopCnt, s + 1);
    check("R7", "scl released", sclOe, 0);
    check("R7", "sda released", sdaOe, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nChecks++; nFails++;
      $display("FAIL R12 watchdog actual=%0d expected<%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int r0, t0, b0;
    r0 = $urandom(32'h5EED1);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #2;

    // R11 reset state
    check("R11", "bufValid", bufValid, 0);
    check("R11", "sclOe", sclOe, 0);
    check("R11", "sdaOe", sdaOe, 0);
    check("R11", "chanOn", chanOn, 1);
    check("R11", "cmdError", cmdError, 0);
    check("R11", "nackRcvd", nackRcvd, 0);
    check("R12", "engineBusy", engineBusy, 0);

    // R7 stop on a free bus
    putCmd(3'd6, 8'h00); waitIdle();
    check("R7", "idle stop no stop cond", stopCnt, 0);
    check("R7", "idle stop no scl", riseCnt, 0);
    check("R2", "tbufInd count", tbCnt, 1);

    // R9 illegal codes
    putCmd(3'd1, 8'h11); waitIdle();
    check("R9", "cmdError code1", cmdError, 1);
    check("R9", "tbufInd code1", tbCnt, 2);
    putCmd(3'd7, 8'h22); waitIdle();
    check("R9", "cmdError code7", cmdError, 1);
    check("R9", "no scl activity", riseCnt, 0);

    // R4 start + address, R3 standard timing
    doStart(3'd4, 8'hA4, "R4");
    check("R3", "std high len", lastHigh, expHigh(0, 1));
    check("R3", "std low len", lastLow, expLow(0, 1));

    // R1 / R10 buffer full while busy
    role = ROLE_ACK;
    b0 = byteCnt; t0 = tbCnt;
    putCmd(3'd0, 8'hA5);
    while (!engineBusy) @(negedge clk);
    cmdWord = {3'd0, 8'h3C}; cmdWrite = 1'b1;
    @(negedge clk);
    cmdWrite = 1'b0;
    check("R1", "bufValid after write", bufValid, 1);
    cmdWord = {3'd0, 8'hFF}; cmdWrite = 1'b1;
    @(negedge clk);
    cmdWrite = 1'b0; chanIdleReq = 1'b1;
    @(negedge clk);
    chanIdleReq = 1'b0;
    check("R10", "idleRefused", idleRefused, 1);
    check("R10", "chanOn kept", chanOn, 1);
    waitIdle();
    check("R1", "buffered byte sent", lastByte, 8'h3C);
    check("R1", "dropped write", byteCnt, b0 + 2);
    check("R2", "two takes", tbCnt, t0 + 2);

    // R5 NACK + R3 fast timing
    fastMode = 1'b1; prescale = 8'd2;
    doWrite(8'h5A, 1'b0);
    check("R3", "fast high len", lastHigh, expHigh(1, 2));
    check("R3", "fast low len", lastLow, expLow(1, 2));

    // R6 reads
    doRead(8'hC3, 1'b1);
    doRead(8'h69, 1'b0);

    // R8 repeated starts
    doStart(3'd5, 8'h51, "R8");
    doStart(3'd4, 8'h52, "R8");
    doStop();

    // R10 idle accepted, writes ignored, re-enable
    fastMode = 1'b0; prescale = 8'd0;
    chanIdleReq = 1'b1; @(negedge clk); chanIdleReq = 1'b0; #2;
    check("R10", "chanOn cleared", chanOn, 0);
    t0 = tbCnt;
    putCmd(3'd4, 8'h10);
    #2;
    check("R10", "write ignored", bufValid, 0);
    repeat (4) @(negedge clk);
    check("R10", "no take", tbCnt, t0);
    chanEnReq = 1'b1; @(negedge clk); chanEnReq = 1'b0; #2;
    check("R10", "chanOn set", chanOn, 1);

    // Random transactions
    for (int s = 0; s < 6; s++) begin
      int nb;
      fastMode = 1'($urandom % 2);
      prescale = 8'($urandom % 3);
      doStart(3'd4, 8'($urandom) & 8'hFE, "R4");
      nb = 1 + int'($urandom % 3);
      for (int k = 0; k < nb; k++) begin
        if ($urandom % 2) doWrite(8'($urandom), 1'($urandom % 2));
        else              doRead(8'($urandom), 1'($urandom % 2));
      end
      check("R3", "random high len", lastHigh, expHigh(fastMode, int'(prescale)));
      doStop();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule